// File: doc/BRIEF.md
# Pin-Selectable Binary-Scaled Clock Divider

The block divides a fast input clock by 10, 20, 40 or 80 and drives one divided output. A fixed divide-by-five prescaler feeds three cascaded divide-by-two stages. Each high bit on the three-bit select input bypasses one of those stages. An output toggle flop follows the chain. The whole period is therefore `10 × 2^(3 − k)`, where `k` is the number of select bits that are high. The position of the high bits does not matter. Everything runs on the one input clock, using clock enables, and the output comes straight from a flop.

A small phase machine sets the output level. It has three states. `ST_LOAD` is entered on reset and lasts one cycle. In that cycle the counters are held and the sampled select is copied into the active selection. `ST_LOW` and `ST_HIGH` are the two output half-periods. The transitions are:
- **T_START**: `ST_LOAD` to `ST_LOW`, taken unconditionally.
- **T_RISE**: `ST_LOW` to `ST_HIGH`, taken on a half-period terminal count.
- **T_FALL**: `ST_HIGH` to `ST_LOW`, taken on a half-period terminal count. This transition also copies the sampled select into the active selection.

The select pins are registered on every clock. A new ratio therefore starts only at the boundary between two full output periods, and no short pulse can appear.

Top module: `binscale_clkdiv`

## Requirements
- R1: With the select inputs held, the full output period is 80 input cycles when no select bit is high, 40 when one is high, 20 when two are high and 10 when all three are high, so each half-period is 5 × 2^(3 − k) cycles for k high bits.
- R2: The ratio depends only on how many select bits are high, not on which ones.
- R3: The output is high and low for an equal number of input cycles at every ratio (50 % duty).
- R4: Reset is synchronous and active high: the output is low after the first clock edge that samples reset high, and it stays low while reset is held.
- R5: After reset is released, the first edge only loads the selection and the output stays low. The first rising output edge comes at edge 1 + H after release, where H is the half-period in R1.
- R6: A select change takes effect at the next high-to-low output transition. The output period in progress finishes with the old half-period, and the low phase that follows uses the new one.
- R7: A select excursion that is undone before the next high-to-low output transition has no effect on any half-period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock; the only clock domain |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | NUM_STAGES (3) | Stage bypass selects; each high bit halves the ratio |
| div_o | output | 1 | Registered divided clock output |

## Verification
The bench builds the block with its default parameters: a prescale of five and three halving stages. This keeps every half-period at 40 cycles or less. The sweep can therefore cover all eight select patterns, each with reset-to-first-edge latency and full high and low runs. Because the parameters are small, switching the select during the high phase and during the low phase takes only a few periods, and so does a short excursion that is undone before the next boundary. The expected half-period comes from the popcount of the select in the bench.

// File: rtl/binscale_pkg.sv
package binscale_pkg;

    // Output phase of the divider.
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } phase_e;

    // Number of input cycles in one output half-period.
    function automatic int unsigned half_len(input int unsigned pre,
                                             input int unsigned stages,
                                             input int unsigned set_bits);
        return pre << (stages - set_bits);
    endfunction

endpackage

// File: rtl/binscale_prediv.sv
module binscale_prediv #(
    parameter int unsigned PRE_DIV = 5
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/binscale_halver.sv
module binscale_halver (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bypass_i,
    input  logic en_i,
    output logic en_o
);
    logic half_q;

    // A bypassed stage is held clear, so it is ready when re-enabled.
    always_ff @(posedge clk_i) begin
        if (rst_i || bypass_i) begin
            half_q <= 1'b0;
        end else if (en_i) begin
            half_q <= ~half_q;
        end
    end

    assign en_o = bypass_i ? en_i : (en_i & half_q);

endmodule

// File: rtl/binscale_phase_fsm.sv
module binscale_phase_fsm
    import binscale_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  half_tc_i,
    input  logic [NUM_STAGES-1:0] sel_q_i,
    output logic                  load_o,
    output logic [NUM_STAGES-1:0] active_sel_o,
    output logic                  div_o
);
    phase_e state_q;
    phase_e state_d;

    // State register.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: state_d = ST_LOW;                        // T_START
            ST_LOW:  if (half_tc_i) state_d = ST_HIGH;        // T_RISE
            ST_HIGH: if (half_tc_i) state_d = ST_LOW;         // T_FALL
            default: state_d = ST_LOAD;
        endcase
    end

    // Registered outputs: divided clock and the selection in force.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_o        <= 1'b0;
            active_sel_o <= '0;
        end else begin
            div_o <= (state_d == ST_HIGH);
            if ((state_q == ST_LOAD) || ((state_q == ST_HIGH) && half_tc_i)) begin
                active_sel_o <= sel_q_i;
            end
        end
    end

    assign load_o = (state_q == ST_LOAD);

endmodule

// File: rtl/binscale_clkdiv.sv
module binscale_clkdiv #(
    parameter int unsigned PRE_DIV    = 5,
    parameter int unsigned NUM_STAGES = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [NUM_STAGES-1:0] sel_i,
    output logic                  div_o
);
    logic [NUM_STAGES-1:0] sel_q;
    logic [NUM_STAGES-1:0] active_sel;
    logic [NUM_STAGES:0]   en_chain;
    logic                  in_load;
    logic                  pre_tick;

    // Select pins are sampled every cycle; they are used only at boundaries.
    always_ff @(posedge clk_i) begin
        sel_q <= sel_i;
    end

    binscale_prediv #(
        .PRE_DIV (PRE_DIV)
    ) u_prediv (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (!in_load),
        .tick_o (pre_tick)
    );

    assign en_chain[0] = pre_tick;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        binscale_halver u_halver (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .bypass_i (active_sel[g]),
            .en_i     (en_chain[g]),
            .en_o     (en_chain[g+1])
        );
    end

    binscale_phase_fsm #(
        .NUM_STAGES (NUM_STAGES)
    ) u_phase (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .half_tc_i    (en_chain[NUM_STAGES]),
        .sel_q_i      (sel_q),
        .load_o       (in_load),
        .active_sel_o (active_sel),
        .div_o        (div_o)
    );

endmodule

// File: rtl/binscale_clkdiv_chk.sv
module binscale_clkdiv_chk
    import binscale_pkg::*;
#(
    parameter int unsigned PRE_DIV    = 5,
    parameter int unsigned NUM_STAGES = 3
) (
    input logic                  clk_i,
    input logic                  rst_i,
    input logic                  div_o,
    input logic                  load_i,
    input logic [NUM_STAGES-1:0] active_sel_i
);
    logic        prev_out;
    logic        armed;
    int unsigned run_len;
    int unsigned exp_len;
    int unsigned half_now;

    assign half_now = half_len(PRE_DIV, NUM_STAGES, $countones(active_sel_i));

    // Length of each output level, measured against the ratio in force at its start.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_out <= 1'b0;
            armed    <= 1'b0;
            run_len  <= 0;
            exp_len  <= 0;
        end else if (div_o != prev_out) begin
            prev_out <= div_o;
            armed    <= 1'b1;
            run_len  <= 1;
            exp_len  <= half_now;
        end else begin
            run_len  <= run_len + 1;
        end
    end

    AST_RESET_DRIVES_LOW: assert property (@(posedge clk_i)
        rst_i |=> !div_o);                                                    // R4

    AST_HALF_PERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
        (armed && (div_o != prev_out)) |-> (run_len == exp_len));             // R1

    AST_SEL_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(load_i) && (active_sel_i != $past(active_sel_i))) |-> $fell(div_o)); // R6

    AST_LOAD_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |-> !div_o);                                                   // R5

endmodule

bind binscale_clkdiv binscale_clkdiv_chk #(
    .PRE_DIV    (PRE_DIV),
    .NUM_STAGES (NUM_STAGES)
) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .div_o        (div_o),
    .load_i       (in_load),
    .active_sel_i (active_sel)
);

// File: tb/binscale_clkdiv_tb.sv
module binscale_clkdiv_tb_top;

    localparam int unsigned PRE  = 5;
    localparam int unsigned NSTG = 3;
    localparam int unsigned WD_CYCLES = 100000;

    logic            clk = 1'b0;
    logic            rst_i = 1'b1;
    logic [NSTG-1:0] sel_i = '0;
    logic            div_o;

    int n_checks = 0;
    int n_errs   = 0;

    binscale_clkdiv #(
        .PRE_DIV    (PRE),
        .NUM_STAGES (NSTG)
    ) dut_i (
        .clk_i (clk),
        .rst_i (rst_i),
        .sel_i (sel_i),
        .div_o (div_o)
    );

    // 50 MHz
    always #10 clk = ~clk;

    function automatic int exp_half(input logic [NSTG-1:0] s);
        return PRE * (1 << (NSTG - $countones(s)));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Counts negedges on which the current level holds, starting at the first one.
    // Optionally drives an excursion on sel_i during the first three of them.
    task automatic count_run(output int n, input bit pulse,
                             input logic [NSTG-1:0] alt, input logic [NSTG-1:0] home);
        logic v;
        v = div_o;
        n = 1;
        if (pulse) sel_i = alt;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (pulse && (n == 3)) sel_i = home;
            if (div_o != v) break;
            n++;
        end
    endtask

    task automatic release_and_rise(output int n);
        rst_i = 1'b0;
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            n++;
            if (div_o) break;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_errs++;
        $display("FAIL R1 watchdog: actual %0d cycles expected fewer", WD_CYCLES);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        int r;
        int h;

        @(negedge clk);
        @(negedge clk);
        check(div_o == 1'b0, "R4", "output in reset at start", int'(div_o), 0);

        // Sweep every select pattern.
        for (int s = 0; s < (1 << NSTG); s++) begin
            sel_i = NSTG'(s);
            h = exp_half(NSTG'(s));
            if (s != 0) begin
                // Enter reset while the output is high.
                for (int i = 0; i < 400 && !div_o; i++) @(negedge clk);
                rst_i = 1'b1;
                @(negedge clk);
                check(div_o == 1'b0, "R4", "low one edge after reset", int'(div_o), 0);
                @(negedge clk);
                check(div_o == 1'b0, "R4", "low while reset held", int'(div_o), 0);
            end
            release_and_rise(r);
            check(r == h + 1, "R5", $sformatf("first rise sel=%0d", s), r, h + 1);
            count_run(r, 1'b0, '0, '0);
            check(r == h, "R1 R2", $sformatf("high run sel=%0d", s), r, h);
            count_run(r, 1'b0, '0, '0);
            check(r == h, "R3", $sformatf("low run sel=%0d", s), r, h);
            count_run(r, 1'b0, '0, '0);
            check(r == h, "R2", $sformatf("second high run sel=%0d", s), r, h);
        end

        // Change during the high phase: 3'b011 (half 10) -> 3'b111 (half 5).
        sel_i = 3'b011;
        rst_i = 1'b1;
        repeat (2) @(negedge clk);
        release_and_rise(r);
        check(r == 11, "R5", "first rise sel=3", r, 11);
        sel_i = 3'b111;
        count_run(r, 1'b0, '0, '0);
        check(r == 10, "R6", "high phase keeps old ratio", r, 10);
        count_run(r, 1'b0, '0, '0);
        check(r == 5, "R6", "low after boundary uses new ratio", r, 5);
        count_run(r, 1'b0, '0, '0);
        check(r == 5, "R6", "high with new ratio", r, 5);

        // Change during the low phase: 3'b111 (half 5) -> 3'b001 (half 20).
        sel_i = 3'b001;
        count_run(r, 1'b0, '0, '0);
        check(r == 5, "R6", "low phase keeps old ratio", r, 5);
        count_run(r, 1'b0, '0, '0);
        check(r == 5, "R6", "high phase of same period keeps old ratio", r, 5);
        count_run(r, 1'b0, '0, '0);
        check(r == 20, "R6", "next period uses new ratio", r, 20);
        count_run(r, 1'b0, '0, '0);
        check(r == 20, "R6", "high with new ratio", r, 20);

        // Excursion to 3'b000 for three cycles inside a low phase, then back.
        count_run(r, 1'b1, 3'b000, 3'b001);
        check(r == 20, "R7", "low run during excursion", r, 20);
        count_run(r, 1'b0, '0, '0);
        check(r == 20, "R7", "high run after excursion", r, 20);
        count_run(r, 1'b0, '0, '0);
        check(r == 20, "R7", "low run after boundary", r, 20);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule